// File: doc/BRIEF.md
# Exhaustive and Weighted Test Pattern Generator

This block feeds test vectors to a combinational circuit under test during built-in self-test. In exhaustive mode it walks a maximum-length linear feedback shift register through its whole cycle. A zero-detect term in the feedback also lets the register pass through the all-zero state. The result is every one of the 2^W input vectors exactly once, with no repeats.

In weighted mode the register runs through the same sequence, but each output bit goes through a small per-bit network of register taps. The network sets the probability of a 1 on that bit to 1/2, 1/4, 3/4 or 1/8. This mode stops after a programmed number of patterns.

A one-cycle start pulse loads the fixed nonzero seed and begins a run. The mode and the pattern count are captured on that pulse. Each valid pattern is marked by the valid strobe. When the run ends, the done flag rises and stays high until the next start.

Top module: `patgen_top`

## Requirements
- R1: While reset is active and after its release, `valid_o` and `done_o` are 0 until the first start.
- R2: In the cycle after `start_i` is sampled with a nonzero run length, `valid_o` is 1, `done_o` is 0, and the generator state equals the seed (default 8'hA5). In exhaustive mode, `pattern_o` shows that state.
- R3: An exhaustive run (`mode_i`=0) presents 2^W valid patterns, and each W-bit value appears exactly once.
- R4: The all-zero pattern immediately follows the pattern with only the MSB set, and is itself followed by the pattern 1.
- R5: Each advance shifts the state left by one and inserts a feedback bit. The feedback bit is s[7]^s[5]^s[4]^s[3], inverted when s[6:0] is all zero.
- R6: After the last pattern of a run, `valid_o` falls and `done_o` rises in the same cycle. `done_o` holds until the next start. The two are never high together.
- R7: A weighted run (`mode_i`=1) presents exactly `count_i` valid patterns, then completes as in R6.
- R8: In weighted mode, the 2-bit field `weight_i[2j+1:2j]` sets output bit j from state s, with a=s[j], b=s[(j+3)%W] and c=s[(j+5)%W]. Code 0 gives a. Code 1 gives a&b. Code 2 gives a|b. Code 3 gives a&b&c.
- R9: A weighted start with `count_i`=0 raises `done_o` in the next cycle, with no valid pattern.
- R10: A start during a run restarts it: the next pattern is the seed and the full length is counted again.
- R11: `mode_i` and `count_i` are sampled only at start. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin or restart a run |
| mode_i | input | 1 | 0 exhaustive, 1 weighted |
| weight_i | input | 2*W | Per-bit weight code, 2 bits per output |
| count_i | input | CNT_W | Pattern count for weighted runs |
| pattern_o | output | W | Test pattern |
| valid_o | output | 1 | Pattern valid this cycle |
| done_o | output | 1 | Run complete |

## Verification
The bench records every exhaustive pattern in a seen-map, so a generator that never inserts zero shows up as 255 distinct values. It also checks the pattern that follows 0x80, so a zero inserted at the wrong point is caught. A reference model of the shift sequence and the weighting network is compared on every clock. Swapped taps in the weighting network therefore give wrong bits, and an off-by-one in the run length gives a wrong count or a late done. Further runs cover a zero count, a restart in mid-run and inputs changed during a run, which catch a design that ignores the empty case or does not latch mode and count at start.

// File: rtl/patgen_pkg.sv
package patgen_pkg;
  typedef enum logic {
    MODE_EXH = 1'b0,
    MODE_WGT = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    WGT_HALF   = 2'd0,
    WGT_QUART  = 2'd1,
    WGT_3QUART = 2'd2,
    WGT_EIGHTH = 2'd3
  } weight_e;
endpackage

// File: rtl/patgen_lfsr.sv
module patgen_lfsr #(
  parameter int unsigned      W    = 8,
  parameter logic [W-1:0]     TAPS = 8'b1011_1000,
  parameter logic [W-1:0]     SEED = 8'hA5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] state_q;
  logic         fb;

  // zero-detect on the lower bits splices the all-zero state into the cycle
  assign fb = (^(state_q & TAPS)) ^ (state_q[W-2:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= SEED;
    else if (load_i)  state_q <= SEED;
    else if (adv_i)   state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;

  // R4
  zero_insert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && state_q == MSB_ONLY) |=> state_q == '0);
  // R4
  zero_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && state_q == '0) |=> state_q == W'(1));
  // R2
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_q == SEED);
endmodule

// File: rtl/patgen_weight.sv
module patgen_weight
  import patgen_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   state_i,
  input  logic [2*W-1:0] weight_i,
  output logic [W-1:0]   pat_o
);
  for (genvar j = 0; j < W; j++) begin : g_bit
    localparam int unsigned JB = (j + 3) % W;
    localparam int unsigned JC = (j + 5) % W;
    weight_e sel;
    assign sel = weight_e'(weight_i[2*j +: 2]);

    always_comb begin
      unique case (sel)
        WGT_HALF:   pat_o[j] = state_i[j];
        WGT_QUART:  pat_o[j] = state_i[j] & state_i[JB];
        WGT_3QUART: pat_o[j] = state_i[j] | state_i[JB];
        default:    pat_o[j] = state_i[j] & state_i[JB] & state_i[JC];
      endcase
    end

    // R8
    always_comb begin
      weight_bound_chk: assert (sel == WGT_3QUART || !pat_o[j] || state_i[j]);
    end
  end
endmodule

// File: rtl/patgen_ctrl.sv
module patgen_ctrl
  import patgen_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             valid_o,
  output logic             done_o,
  output mode_e            mode_o
);
  localparam int unsigned      EXH_INT = 2 ** W;
  localparam logic [CNT_W-1:0] EXH_LEN = CNT_W'(EXH_INT);

  logic             run_q, done_q;
  logic [CNT_W-1:0] cnt_q, lim_q, start_lim, cnt_nxt;
  mode_e            mode_q;

  assign start_lim = (mode_e'(mode_i) == MODE_WGT) ? count_i : EXH_LEN;
  assign cnt_nxt   = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
      mode_q <= MODE_EXH;
    end else if (start_i) begin
      mode_q <= mode_e'(mode_i);
      lim_q  <= start_lim;
      cnt_q  <= '0;
      run_q  <= (start_lim != '0);
      done_q <= (start_lim == '0);
    end else if (run_q) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt == lim_q) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign load_o  = start_i;
  assign adv_o   = run_q & ~start_i;
  assign valid_o = run_q;
  assign done_o  = done_q;
  assign mode_o  = mode_q;

  // R6
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_q && done_q));
  // R6
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> done_q);
  // R7
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q < lim_q);
  // R9
  empty_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i && count_i == '0) |=> (done_q && !run_q));
  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == '0);
endmodule

// File: rtl/patgen_top.sv
module patgen_top
  import patgen_pkg::*;
#(
  parameter int unsigned  W     = 8,
  parameter int unsigned  CNT_W = 16,
  parameter logic [W-1:0] TAPS  = 8'b1011_1000,
  parameter logic [W-1:0] SEED  = 8'hA5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [2*W-1:0]   weight_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [W-1:0]     pattern_o,
  output logic             valid_o,
  output logic             done_o
);
  logic         load, adv;
  logic [W-1:0] state, wpat;
  mode_e        mode_q;

  patgen_ctrl #(.W(W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (mode_i),
    .count_i (count_i),
    .load_o  (load),
    .adv_o   (adv),
    .valid_o (valid_o),
    .done_o  (done_o),
    .mode_o  (mode_q)
  );

  patgen_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .adv_i   (adv),
    .state_o (state)
  );

  patgen_weight #(.W(W)) u_weight (
    .state_i  (state),
    .weight_i (weight_i),
    .pat_o    (wpat)
  );

  assign pattern_o = (mode_q == MODE_WGT) ? wpat : state;

  // R1
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(start_i) && !$past(valid_o) && !$past(done_o)) |-> (!valid_o && !done_o));
endmodule

// File: tb/patgen_top_bench.sv
module patgen_top_bench;
  localparam int W     = 8;
  localparam int CNT_W = 16;
  localparam int SEED  = 8'hA5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             mode = 1'b0;
  logic [2*W-1:0]   weight = '0;
  logic [CNT_W-1:0] count = '0;
  logic [W-1:0]     pattern;
  logic             valid, done;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  patgen_top u_patgen_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .weight_i(weight), .count_i(count),
    .pattern_o(pattern), .valid_o(valid), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int step(input int s);
    int fb;
    fb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
    if ((s & 8'h7F) == 0) fb = fb ^ 1;
    return ((s << 1) | fb) & 8'hFF;
  endfunction

  function automatic int weigh(input int s, input int w);
    int r, a, b, c;
    r = 0;
    for (int j = 0; j < W; j++) begin
      a = (s >> j) & 1;
      b = (s >> ((j + 3) % W)) & 1;
      c = (s >> ((j + 5) % W)) & 1;
      case ((w >> (2 * j)) & 3)
        0: r |= a << j;
        1: r |= (a & b) << j;
        2: r |= (a | b) << j;
        default: r |= (a & b & c) << j;
      endcase
    end
    return r;
  endfunction

  // reference model
  int m_state = SEED, m_cnt = 0, m_lim = 0;
  bit m_run = 0, m_done = 0, m_mode = 0;
  int run_valids = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = SEED; m_run = 0; m_done = 0; m_cnt = 0; m_mode = 0;
    end else if (start) begin
      m_state = SEED; m_mode = mode; m_lim = mode ? int'(count) : 256;
      m_cnt = 0; m_run = (m_lim != 0); m_done = (m_lim == 0);
      run_valids = 0;
    end else if (m_run) begin
      m_state = step(m_state); m_cnt++;
      if (m_cnt == m_lim) begin m_run = 0; m_done = 1; end
    end
  end

  bit seen [256];
  int prev = -1;
  bit collect = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int exp_p;
      chk(valid == m_run, "R6 valid", valid, m_run);
      chk(done == m_done, "R6 done", done, m_done);
      if (m_run) begin
        exp_p = m_mode ? weigh(m_state, weight) : m_state;
        chk(pattern == exp_p, m_mode ? "R8 pattern" : "R5 pattern", pattern, exp_p);
      end
      if (valid) begin
        run_valids++;
        if (collect) begin
          if (prev == 8'h80) chk(pattern == 0, "R4 zero after 0x80", pattern, 0);
          if (prev == 0) chk(pattern == 1, "R4 one after zero", pattern, 1);
          seen[pattern] = 1;
          prev = pattern;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic kick(input bit md, input int n);
    @(negedge clk);
    mode = md; count = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    int distinct;
    repeat (3) @(negedge clk);
    chk(!valid && !done, "R1 in reset", {valid, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!valid && !done, "R1 after reset", {valid, done}, 0);

    // exhaustive run
    collect = 1;
    foreach (seen[i]) seen[i] = 0;
    kick(0, 0);
    chk(valid && !done && pattern == SEED, "R2 seed first", pattern, SEED);
    wait_done();
    collect = 0;
    distinct = 0;
    foreach (seen[i]) distinct += seen[i];
    chk(distinct == 256, "R3 distinct", distinct, 256);
    chk(run_valids == 256, "R3 count", run_valids, 256);
    repeat (4) @(negedge clk);
    chk(done && !valid, "R6 done held", {valid, done}, 1);

    // weighted, mixed codes, inputs changed mid-run
    weight = 16'b11_10_01_00_00_01_10_11;
    kick(1, 40);
    repeat (10) @(negedge clk);
    mode = 0; count = 16'd5;
    wait_done();
    chk(run_valids == 40, "R11 latched count", run_valids, 40);
    chk(run_valids == 40, "R7 weighted length", run_valids, 40);

    // weighted, all eighth, long run across wrap
    weight = '1;
    kick(1, 300);
    wait_done();
    chk(run_valids == 300, "R7 long run", run_valids, 300);

    // weighted, all three-quarter
    weight = 16'hAAAA;
    kick(1, 17);
    wait_done();
    chk(run_valids == 17, "R8 or weight run", run_valids, 17);

    // zero count
    kick(1, 0);
    chk(done && !valid, "R9 empty run", {valid, done}, 1);
    repeat (3) @(negedge clk);
    chk(run_valids == 0, "R9 no patterns", run_valids, 0);

    // restart mid-run
    kick(0, 0);
    repeat (20) @(negedge clk);
    kick(0, 0);
    chk(valid && pattern == SEED, "R10 restart seed", pattern, SEED);
    wait_done();
    chk(run_valids == 256, "R10 full length", run_valids, 256);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule